// File: doc/BRIEF.md
# Unaligned Memory Access Splitter

This block sits between a load/store unit and a memory port that is 32 bits wide and only accepts naturally aligned word addresses. The core side hands over one access at a time: a byte, a 16-bit half, a 32-bit word or a 64-bit quad, at any byte address and with no alignment trap. The block turns each access into the smallest run of aligned bus transactions that covers the addressed bytes. Each transaction carries byte enables for exactly the lanes the access touches.

For a store, the operand bytes are shifted onto their lanes in little-endian order: operand byte k goes to address A+k. For a load, the returned lanes are collected across all transactions and shifted down into a right-justified, zero-extended 64-bit value. Lanes that are not enabled are dropped. A single response pulse closes every access. The core may issue the next access in that same cycle.

Top module: `unaligned_splitter`

## Requirements
- R1: After reset, req_ready is 1 and both mem_valid and rsp_valid are 0.
- R2: req_size encodes 0 = byte, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Byte k of the operand (bits 8k+7..8k) belongs to byte address req_addr+k, so the lowest address holds the least significant byte.
- R3: An access whose bytes all lie inside one aligned 4-byte word is done with exactly one memory handshake.
- R4: An access crossing one 4-byte boundary takes two handshakes. A 64-bit access takes two when its address is a multiple of 4 and three otherwise.
- R5: Transactions are issued at increasing word addresses, lowest first, each 4 above the previous one, and mem_addr has its two low bits at 0.
- R6: mem_be bit l (lane l = mem_wdata/mem_rdata bits 8l+7..8l = address mem_addr+l) is set exactly for the lanes belonging to the access. For stores, mem_write is 1 and every enabled lane of mem_wdata carries the operand byte for that address.
- R7: A load returns the addressed bytes right-justified in rsp_rdata with all higher bytes zero. Returned lanes whose byte enable was 0 have no effect on the result.
- R8: rsp_valid is a one-cycle pulse in the cycle after the last memory handshake of an access, for loads and for stores alike. rsp_rdata is 0 for stores.
- R9: req_ready is 0 from the cycle after an access is accepted until its response cycle. While mem_valid is 1 and mem_ready is 0, the transaction (mem_addr, mem_be, mem_wdata) is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents an access |
| req_ready | output | 1 | Block is free to accept an access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (R2) |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 64 | Store operand, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Load result, zero-extended |
| mem_valid | output | 1 | Bus transaction pending |
| mem_ready | input | 1 | Memory completes the transaction this cycle |
| mem_write | output | 1 | Bus transaction is a write |
| mem_addr | output | AW | Word-aligned bus address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Write data by lane |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
The embedded assertions watch four properties on every cycle:
- the word-by-word address progression;
- that a stalled transaction stays stable;
- that the response is a single pulse tied to a final handshake;
- that the core side closes once an access is taken.

Only the bench scenarios can show the rest: whether the enables hit the right lanes, whether store bytes land at the right addresses, whether load bytes are merged and zero-extended correctly, and whether the handshake count per access matches the offset and size. The bench checks these against a byte-addressed memory model, with random stalls and junk on the disabled read lanes.

// File: rtl/split_pkg.sv
`timescale 1ns/1ps
package split_pkg;
  localparam int BUS_B     = 4;
  localparam int BUS_W     = BUS_B * 8;
  localparam int OPD_B     = 8;
  localparam int OPD_W     = OPD_B * 8;
  localparam int OFF_W     = $clog2(BUS_B);
  localparam int NB_W      = $clog2(OPD_B) + 1;
  localparam int MAX_BEATS = OPD_B / BUS_B + 1;
  localparam int WIN_B     = BUS_B * MAX_BEATS;
  localparam int WIN_W     = WIN_B * 8;
  localparam int BEAT_W    = $clog2(MAX_BEATS);

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_QUAD} acc_size_e;
  typedef enum logic {ST_IDLE, ST_RUN} split_state_e;
endpackage

// File: rtl/split_rst_sync.sv
`timescale 1ns/1ps
module split_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic stage0_q, stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_n_s = stage1_q;
endmodule

// File: rtl/split_plan.sv
`timescale 1ns/1ps
module split_plan
  import split_pkg::*;
(
  input  acc_size_e           size,
  input  logic [OFF_W-1:0]    off,
  input  logic [OPD_W-1:0]    wdata,
  output logic [WIN_B-1:0]    be_win,
  output logic [WIN_W-1:0]    data_win,
  output logic [BEAT_W-1:0]   last_idx
);
  logic [NB_W-1:0]  nbytes;
  logic [NB_W-1:0]  last_byte;
  logic [WIN_B-1:0] base_mask;

  always_comb begin
    nbytes = NB_W'(1) << size;
    for (int i = 0; i < WIN_B; i++) begin
      base_mask[i] = (NB_W'(i) < nbytes);
    end
    be_win    = base_mask << off;
    data_win  = {{(WIN_W-OPD_W){1'b0}}, wdata} << {off, 3'b000};
    last_byte = {{(NB_W-OFF_W){1'b0}}, off} + nbytes - NB_W'(1);
    last_idx  = BEAT_W'(last_byte >> OFF_W);
  end
endmodule

// File: rtl/split_merge.sv
`timescale 1ns/1ps
module split_merge
  import split_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  input  logic [OFF_W-1:0] off,
  input  acc_size_e        size,
  output logic [OPD_W-1:0] value
);
  logic [NB_W-1:0]  nbytes;
  logic [WIN_W-1:0] shifted;
  logic [OPD_W-1:0] keep;

  always_comb begin
    nbytes  = NB_W'(1) << size;
    shifted = win >> {off, 3'b000};
    for (int b = 0; b < OPD_B; b++) begin
      keep[b*8 +: 8] = (NB_W'(b) < nbytes) ? 8'hFF : 8'h00;
    end
    value = shifted[OPD_W-1:0] & keep;
  end
endmodule

// File: rtl/unaligned_splitter.sv
`timescale 1ns/1ps
module unaligned_splitter
  import split_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [OPD_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [OPD_W-1:0] rsp_rdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [BUS_B-1:0] mem_be,
  output logic [BUS_W-1:0] mem_wdata,
  input  logic [BUS_W-1:0] mem_rdata
);
  localparam int WA_W = AW - OFF_W;

  logic rst_n_s;

  split_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  // request-side decode
  acc_size_e         in_size;
  logic [WIN_B-1:0]  in_be_win;
  logic [WIN_W-1:0]  in_data_win;
  logic [BEAT_W-1:0] in_last;

  assign in_size = acc_size_e'(req_size);

  split_plan u_plan (
    .size(in_size), .off(req_addr[OFF_W-1:0]), .wdata(req_wdata),
    .be_win(in_be_win), .data_win(in_data_win), .last_idx(in_last)
  );

  // state
  split_state_e      state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              beat_en;
  logic              write_q;
  acc_size_e         size_q;
  logic [OFF_W-1:0]  off_q;
  logic [WA_W-1:0]   waddr_q;
  logic [BEAT_W-1:0] last_q;
  logic [WIN_B-1:0]  be_win_q;
  logic [WIN_W-1:0]  data_win_q;
  logic [WIN_W-1:0]  rbuf_q, rbuf_d;
  logic              rbuf_en;
  logic              rsp_valid_q, rsp_valid_d;
  logic [OPD_W-1:0]  rsp_rdata_q, rsp_rdata_d;
  logic              rsp_en;
  logic [OPD_W-1:0]  merged;
  logic              accept, hs, done, run;

  assign run       = (state_q == ST_RUN);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hs        = run && mem_ready;
  assign done      = hs && (beat_q == last_q);

  // bus side
  assign mem_valid = run;
  assign mem_write = run && write_q;
  assign mem_addr  = {waddr_q + WA_W'(beat_q), {OFF_W{1'b0}}};
  assign mem_be    = run ? be_win_q[int'(beat_q)*BUS_B +: BUS_B] : '0;
  assign mem_wdata = data_win_q[int'(beat_q)*BUS_W +: BUS_W];

  split_merge u_merge (.win(rbuf_d), .off(off_q), .size(size_q), .value(merged));

  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    beat_en     = 1'b0;
    rbuf_d      = rbuf_q;
    rbuf_en     = 1'b0;
    rsp_valid_d = done;
    rsp_rdata_d = write_q ? '0 : merged;
    rsp_en      = done;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_RUN;
        beat_d  = '0;
        beat_en = 1'b1;
      end
      ST_RUN: begin
        if (hs) begin
          rbuf_d[int'(beat_q)*BUS_W +: BUS_W] = mem_rdata;
          rbuf_en = 1'b1;
        end
        if (done) begin
          state_d = ST_IDLE;
        end else if (hs) begin
          beat_d  = beat_q + BEAT_W'(1);
          beat_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (beat_en) beat_q      <= beat_d;
      if (rsp_en)  rsp_rdata_q <= rsp_rdata_d;
    end
  end

  // datapath registers, loaded on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      write_q    <= req_write;
      size_q     <= in_size;
      off_q      <= req_addr[OFF_W-1:0];
      waddr_q    <= req_addr[AW-1:OFF_W];
      last_q     <= in_last;
      be_win_q   <= in_be_win;
      data_win_q <= in_data_win;
    end
    if (rbuf_en) rbuf_q <= rbuf_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + AW'(BUS_B))));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));

  // R9
  busy_close_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready) |=> (!req_ready && mem_valid));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $past(mem_valid && mem_ready));

  // R6
  lanes_used_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_valid |-> (mem_be != '0));
endmodule

// File: tb/unaligned_splitter_test.sv
`timescale 1ns/1ps
module unaligned_splitter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  unaligned_splitter #(.AW(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  int nchk = 0;
  int nerr = 0;

  logic [7:0]  mem [0:255];
  logic [31:0] q_addr [$];
  logic [3:0]  q_be   [$];
  logic [31:0] q_wd   [$];

  bit          hs_pend, acc_pend, exp_rsp, got_rsp, cur_wr, pend_req, stall_mode;
  logic [63:0] exp_data;
  int          hs_seen, exp_beats;
  logic        p_wr;
  logic [1:0]  p_sz;
  logic [31:0] p_addr;
  logic [63:0] p_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock of the reference model, evaluated at the falling edge
  task automatic cycle();
    @(negedge clk);
    exp_rsp = 1'b0;
    if (hs_pend) begin
      if (cur_wr)
        for (int l = 0; l < 4; l++)
          if (q_be[0][l]) mem[8'(q_addr[0] + l)] = q_wd[0][8*l +: 8];
      void'(q_addr.pop_front());
      void'(q_be.pop_front());
      void'(q_wd.pop_front());
      hs_seen++;
      if (q_addr.size() == 0) exp_rsp = 1'b1;
    end
    if (acc_pend) begin
      int nb;
      nb = 1 << p_sz;
      exp_data = '0;
      for (int i = 0; i < nb; i++) begin
        logic [31:0] ba, wa;
        ba = p_addr + i;
        wa = {ba[31:2], 2'b00};
        if (q_addr.size() == 0 || q_addr[q_addr.size()-1] != wa) begin
          q_addr.push_back(wa);
          q_be.push_back(4'b0);
          q_wd.push_back(32'b0);
        end
        q_be[q_be.size()-1][ba[1:0]] = 1'b1;
        q_wd[q_wd.size()-1][8*ba[1:0] +: 8] = p_data[8*i +: 8];
        if (!p_wr) exp_data[8*i +: 8] = mem[ba[7:0]];
      end
      cur_wr    = p_wr;
      hs_seen   = 0;
      exp_beats = q_addr.size();
      req_valid = 1'b0;
      req_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      pend_req  = 1'b0;
      acc_pend  = 1'b0;
    end
    // compare with the design
    chk(req_ready == (q_addr.size() == 0), "R9", "req_ready", 64'(req_ready), 64'(q_addr.size() == 0));
    chk(mem_valid == (q_addr.size() != 0), "R5", "mem_valid", 64'(mem_valid), 64'(q_addr.size() != 0));
    if (q_addr.size() != 0 && mem_valid) begin
      chk(mem_addr == q_addr[0], "R5", "mem_addr", 64'(mem_addr), 64'(q_addr[0]));
      chk(mem_be == q_be[0], "R6", "mem_be", 64'(mem_be), 64'(q_be[0]));
      chk(mem_write == cur_wr, "R6", "mem_write", 64'(mem_write), 64'(cur_wr));
      if (cur_wr) begin
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{q_be[0][l]}};
        chk((mem_wdata & m) == q_wd[0], "R2 R6", "store lanes", 64'(mem_wdata & m), 64'(q_wd[0]));
      end
    end
    chk(rsp_valid == exp_rsp, "R8", "rsp_valid", 64'(rsp_valid), 64'(exp_rsp));
    if (exp_rsp) begin
      got_rsp = 1'b1;
      chk(rsp_rdata == exp_data, cur_wr ? "R8" : "R2 R7", "rsp_rdata", rsp_rdata, exp_data);
      if (exp_beats == 1)
        chk(hs_seen == 1, "R3", "handshakes", 64'(hs_seen), 64'd1);
      else
        chk(hs_seen == exp_beats, "R4", "handshakes", 64'(hs_seen), 64'(exp_beats));
    end
    // drive the memory side for the next edge
    if (q_addr.size() != 0) begin
      mem_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      for (int l = 0; l < 4; l++)
        mem_rdata[8*l +: 8] = q_be[0][l] ? mem[8'(q_addr[0] + l)] : (8'hC3 ^ 8'(l * 17));
    end else begin
      mem_ready = 1'($urandom_range(0, 1));
      mem_rdata = 32'h5A5A_A5A5;
    end
    hs_pend = (q_addr.size() != 0) && mem_ready;
    if (pend_req && q_addr.size() == 0 && !acc_pend) begin
      req_valid = 1'b1;
      req_write = p_wr;
      req_size  = p_sz;
      req_addr  = p_addr;
      req_wdata = p_data;
      acc_pend  = 1'b1;
    end
  endtask

  task automatic issue(input logic wr, input logic [1:0] sz,
                       input logic [31:0] addr, input logic [63:0] data);
    int guard;
    p_wr = wr; p_sz = sz; p_addr = addr; p_data = data;
    pend_req = 1'b1;
    got_rsp  = 1'b0;
    guard = 0;
    while (!got_rsp) begin
      cycle();
      guard++;
      if (guard > 500) begin
        chk(1'b0, "R8", "watchdog expired", 64'(guard), 64'd0);
        pend_req = 1'b0;
        break;
      end
    end
  endtask

  // quadword beat counts checked against R4 directly
  task automatic quad_count(input logic [31:0] addr);
    int want;
    want = (addr[1:0] == 2'b00) ? 2 : 3;
    issue(1'b0, 2'd3, addr, 64'd0);
    chk(hs_seen == want, "R4", "quad handshakes", 64'(hs_seen), 64'(want));
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0;
    mem_ready = 1'b0; mem_rdata = '0;
    hs_pend = 0; acc_pend = 0; exp_rsp = 0; got_rsp = 0; cur_wr = 0;
    pend_req = 0; stall_mode = 0; hs_seen = 0; exp_beats = 0; exp_data = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    chk(mem_valid == 1'b0, "R1", "mem_valid", 64'(mem_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    for (int k = 0; k < 3; k++) cycle();

    // every size at every offset, memory always ready
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++) begin
        logic [31:0] a;
        a = 32'h1000_0040 + 32'(sz * 32) + 32'(off);
        issue(1'b0, 2'(sz), a, 64'd0);
        issue(1'b1, 2'(sz), a, {$urandom, $urandom});
        issue(1'b0, 2'(sz), a, 64'd0);
        cycle();
      end
    // R4 quadword counts
    for (int off = 0; off < 4; off++) quad_count(32'h1000_0010 + 32'(off));

    // random traffic with memory stalls
    stall_mode = 1'b1;
    for (int n = 0; n < 200; n++) begin
      issue(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            32'h2000_0000 | 32'($urandom_range(0, 247)), {$urandom, $urandom});
      if ($urandom_range(0, 3) == 0) cycle();
    end
    for (int k = 0; k < 4; k++) cycle();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule